// File: doc/BRIEF.md
# Latch-Framed Serial Command Receiver

This block is the slave end of a slow serial command link. A host lowers an active-low frame select, sends between one and nine bytes, and raises the select again. Inside a frame, data is taken on each falling edge of the serial clock, most significant bit first: mode 1, with the clock idling low. Each completed byte goes to a downstream command parser as a one-cycle strobe with the byte and its position in the frame. When the select is released, a second strobe reports how many whole bytes the frame held and whether the frame was malformed. A shift-out register drives a caller-supplied reply byte on the data-out line, changing on rising clock edges.

All four pad inputs (clock, data, select and an external reset pin) pass through a two-flop synchronizer and a stability filter before any edge is detected. The filter length comes from the system clock period and the shortest pulse to reject. A rising edge on the reset pin abandons any open frame. The level of the filtered serial clock at that moment selects what the edge means: clock high gives an ordinary reset request, and clock low gives a request to enter programming mode.

Top module: `spi_frame_rx`

## Requirements
- R1: While the frame select is low, each falling edge of the filtered serial clock shifts one data bit in, most significant bit first. After every eighth bit, `byte_valid` pulses for one cycle with the byte on `byte_data` and its frame position on `byte_idx`, counting from 0.
- R2: Each rise of the frame select after a fall gives exactly one `frame_done` pulse, with `frame_bytes` equal to the number of whole bytes received.
- R3: If the bit count at release is not a multiple of 8, `frame_err` pulses together with `frame_done`, and the partial byte is never presented on `byte_valid`.
- R4: Bytes past the ninth are discarded without a `byte_valid` strobe. `frame_bytes` stays at 9 and `frame_err` is raised.
- R5: Clock and data activity while the frame select is high has no effect: no strobes are issued, and the next frame is received correctly.
- R6: A level on any pad input that lasts a single system clock period is rejected: it produces no edge, no extra bit and no frame boundary.
- R7: `miso` presents `tx_byte` most significant bit first, reloaded at the start of every byte. It changes after rising clock edges, so the host reads bit k on falling edge k.
- R8: A rising edge on `rst_pin_pad` gives a one-cycle `dev_reset` if the filtered clock is high, or a one-cycle `prog_req` if it is low. Never both.
- R9: A reset-pin rising edge closes any open frame. The later release of the select produces no `frame_done`.
- R10: If the last falling clock edge and the select release land in the same cycle, the bit is still counted. `byte_valid` and `frame_done` then pulse in the same cycle, and the count includes that byte.
- R11: After system reset, all strobes and `miso` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| sck_pad | input | 1 | Serial clock pad, idle low |
| mosi_pad | input | 1 | Serial data in pad |
| cs_n_pad | input | 1 | Active-low frame select pad |
| rst_pin_pad | input | 1 | External reset pin pad, idle high |
| tx_byte | input | 8 | Reply byte shifted out on `miso` |
| miso | output | 1 | Serial data out |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| byte_idx | output | CNT_W | Position of the byte in its frame |
| frame_done | output | 1 | One-cycle strobe at frame release |
| frame_bytes | output | CNT_W | Whole bytes in the finished frame |
| frame_err | output | 1 | Frame was malformed (partial byte or overflow) |
| dev_reset | output | 1 | Ordinary reset request strobe |
| prog_req | output | 1 | Programming-mode request strobe |

## Verification
The byte strobe and the frame-end strobe can fall in the same cycle. This happens when the last falling clock edge and the rising select arrive together at the pads, so that both filtered edges appear in one system cycle. The bench provokes it by moving both pads at the same instant on the final bit. It judges the result by seeing `byte_valid` and `frame_done` high in the same sampled cycle, with `frame_bytes` counting the final byte and no error flagged.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  // Filter length in system cycles: enough samples to outlast the glitch,
  // plus one so that a pulse exactly one period wide is still rejected.
  function automatic int filt_len(input int clk_period_ps, input int glitch_ps);
    return (glitch_ps + clk_period_ps - 1) / clk_period_ps + 1;
  endfunction

  // Width of a counter able to hold 0..max_val.
  function automatic int cnt_w(input int max_val);
    return $clog2(max_val + 1);
  endfunction

  // A frame is malformed when a partial byte remains or bytes were dropped.
  function automatic logic frame_bad(input logic [2:0] bit_pos, input logic overflow);
    return (bit_pos != 3'd0) || overflow;
  endfunction

endpackage

// File: rtl/spi_rx_filt.sv
module spi_rx_filt #(
  parameter int   LEN     = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad,
  output logic level
);
  localparam int CW = (LEN < 2) ? 1 : $clog2(LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= RST_VAL;
      s2    <= RST_VAL;
      level <= RST_VAL;
      run   <= '0;
    end else begin
      s1 <= pad;
      s2 <= s1;
      if (s2 == level) begin
        run <= '0;
      end else if (run == CW'(LEN - 1)) begin
        level <= s2;
        run   <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_rx_rstdet.sv
module spi_rx_rstdet (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_rise,
  input  logic sck_level,
  output logic dev_reset,
  output logic prog_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_reset <= 1'b0;
      prog_req  <= 1'b0;
    end else begin
      dev_reset <= pin_rise &  sck_level;
      prog_req  <= pin_rise & ~sck_level;
    end
  end
endmodule

// File: rtl/spi_rx_framer.sv
module spi_rx_framer
  import spi_rx_pkg::*;
#(
  parameter int MAX_BYTES = 9,
  localparam int CNT_W = cnt_w(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             mosi,
  input  logic [7:0]       tx_byte,
  output logic             in_frame,
  output logic             miso,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [CNT_W-1:0] byte_idx,
  output logic             frame_done,
  output logic [CNT_W-1:0] frame_bytes,
  output logic             frame_err
);
  logic [7:0]       rx_sh, tx_sh;
  logic [2:0]       bit_pos;
  logic [CNT_W-1:0] byte_cnt;
  logic             ovf;

  logic             take_bit, byte_end, byte_keep, ending;
  logic [7:0]       rx_next;
  logic [2:0]       pos_after;
  logic [CNT_W-1:0] cnt_after;
  logic             ovf_after;

  always_comb begin
    take_bit  = in_frame & sck_fall;
    rx_next   = {rx_sh[6:0], mosi};
    byte_end  = take_bit & (bit_pos == 3'd7);
    byte_keep = byte_end & (byte_cnt < CNT_W'(MAX_BYTES));
    cnt_after = byte_keep ? byte_cnt + 1'b1 : byte_cnt;
    ovf_after = ovf | (byte_end & ~byte_keep);
    pos_after = take_bit ? bit_pos + 3'd1 : bit_pos;
    ending    = in_frame & cs_rise;
  end

  assign miso = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame    <= 1'b0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      bit_pos     <= '0;
      byte_cnt    <= '0;
      ovf         <= 1'b0;
      byte_valid  <= 1'b0;
      byte_data   <= '0;
      byte_idx    <= '0;
      frame_done  <= 1'b0;
      frame_bytes <= '0;
      frame_err   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
      if (clr) begin
        in_frame <= 1'b0;
        bit_pos  <= '0;
        byte_cnt <= '0;
        ovf      <= 1'b0;
      end else if (cs_fall) begin
        in_frame <= 1'b1;
        bit_pos  <= '0;
        byte_cnt <= '0;
        ovf      <= 1'b0;
        tx_sh    <= tx_byte;
      end else begin
        if (in_frame && sck_rise) begin
          tx_sh <= (bit_pos == 3'd0) ? tx_byte : {tx_sh[6:0], 1'b0};
        end
        if (take_bit) begin
          rx_sh    <= rx_next;
          bit_pos  <= pos_after;
          byte_cnt <= cnt_after;
          ovf      <= ovf_after;
          if (byte_keep) begin
            byte_valid <= 1'b1;
            byte_data  <= rx_next;
            byte_idx   <= byte_cnt;
          end
        end
        if (ending) begin
          in_frame    <= 1'b0;
          frame_done  <= 1'b1;
          frame_bytes <= cnt_after;
          frame_err   <= frame_bad(pos_after, ovf_after);
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_rx_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int GLITCH_PS     = 3000,
  parameter int MAX_BYTES     = 9,
  localparam int CNT_W = cnt_w(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_pad,
  input  logic             mosi_pad,
  input  logic             cs_n_pad,
  input  logic             rst_pin_pad,
  input  logic [7:0]       tx_byte,
  output logic             miso,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [CNT_W-1:0] byte_idx,
  output logic             frame_done,
  output logic [CNT_W-1:0] frame_bytes,
  output logic             frame_err,
  output logic             dev_reset,
  output logic             prog_req
);
  localparam int         FILT   = filt_len(CLK_PERIOD_PS, GLITCH_PS);
  localparam int         NPAD   = 4;
  // Idle levels, by index: sck, mosi, cs_n, reset pin.
  localparam logic [3:0] IDLE_V = 4'b1100;

  logic [NPAD-1:0] pads, filt, filt_q;

  assign pads = {rst_pin_pad, cs_n_pad, mosi_pad, sck_pad};

  for (genvar gi = 0; gi < NPAD; gi++) begin : g_filt
    spi_rx_filt #(.LEN(FILT), .RST_VAL(IDLE_V[gi])) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .pad   (pads[gi]),
      .level (filt[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_q <= IDLE_V;
    else        filt_q <= filt;
  end

  // Named edge events, also used by the checker.
  logic sck_rise_w, sck_fall_w, cs_fall_w, cs_rise_w, pin_rise_w, in_frame_w;

  assign sck_rise_w =  filt[0] & ~filt_q[0];
  assign sck_fall_w = ~filt[0] &  filt_q[0];
  assign cs_fall_w  = ~filt[2] &  filt_q[2];
  assign cs_rise_w  =  filt[2] & ~filt_q[2];
  assign pin_rise_w =  filt[3] & ~filt_q[3];

  spi_rx_framer #(.MAX_BYTES(MAX_BYTES)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (pin_rise_w),
    .sck_rise    (sck_rise_w),
    .sck_fall    (sck_fall_w),
    .cs_fall     (cs_fall_w),
    .cs_rise     (cs_rise_w),
    .mosi        (filt[1]),
    .tx_byte     (tx_byte),
    .in_frame    (in_frame_w),
    .miso        (miso),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .byte_idx    (byte_idx),
    .frame_done  (frame_done),
    .frame_bytes (frame_bytes),
    .frame_err   (frame_err)
  );

  spi_rx_rstdet u_rstdet (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_rise  (pin_rise_w),
    .sck_level (filt[0]),
    .dev_reset (dev_reset),
    .prog_req  (prog_req)
  );
endmodule

// File: rtl/spi_frame_rx_chk.sv
module spi_frame_rx_chk #(
  parameter int MAX_BYTES = 9,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_valid,
  input logic             frame_done,
  input logic             frame_err,
  input logic [CNT_W-1:0] frame_bytes,
  input logic             dev_reset,
  input logic             prog_req,
  input logic             in_frame_w,
  input logic             sck_fall_w,
  input logic             cs_rise_w,
  input logic             pin_rise_w
);
  assert_bv_after_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(sck_fall_w));

  assert_done_after_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(cs_rise_w));

  assert_err_only_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> frame_done);

  assert_bytes_capped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_bytes <= CNT_W'(MAX_BYTES)));

  assert_req_from_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_reset || prog_req) |-> $past(pin_rise_w));

  assert_pin_closes_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_reset || prog_req) |-> !in_frame_w);
endmodule

bind spi_frame_rx spi_frame_rx_chk #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .byte_valid  (byte_valid),
  .frame_done  (frame_done),
  .frame_err   (frame_err),
  .frame_bytes (frame_bytes),
  .dev_reset   (dev_reset),
  .prog_req    (prog_req),
  .in_frame_w  (in_frame_w),
  .sck_fall_w  (sck_fall_w),
  .cs_rise_w   (cs_rise_w),
  .pin_rise_w  (pin_rise_w)
);

// File: tb/spi_frame_rx_tb.sv
`timescale 1ns/1ps
module spi_frame_rx_tb;
  localparam int         HALF = 20;
  localparam logic [7:0] TX   = 8'hA5;
  localparam int         NV   = 6;
  // Each entry: {bit count, data left-aligned in 80 bits}.
  localparam logic [87:0] VEC [NV] = '{
    {8'd40, 80'h4332000000_0000000000},
    {8'd8,  80'h53_000000000000000000},
    {8'd72, 80'h4B303033443039303000},
    {8'd12, 80'hC3F0_0000000000000000},
    {8'd80, 80'h0102030405060708090A},
    {8'd16, 80'h444D_0000000000000000}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, sck, mosi, cs_n, rpin;
  logic [7:0] tx_byte;
  logic       miso, byte_valid, frame_done, frame_err, dev_reset, prog_req;
  logic [7:0] byte_data;
  logic [3:0] byte_idx, frame_bytes;

  spi_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sck_pad(sck), .mosi_pad(mosi), .cs_n_pad(cs_n),
    .rst_pin_pad(rpin), .tx_byte(tx_byte), .miso(miso), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_idx(byte_idx), .frame_done(frame_done),
    .frame_bytes(frame_bytes), .frame_err(frame_err), .dev_reset(dev_reset),
    .prog_req(prog_req)
  );

  int checks = 0, fails = 0;
  int nbv, nfd, ndev, nprog, mmis;
  logic       same, fd_err;
  logic [3:0] fd_bytes;
  logic [7:0] got  [16];
  logic [3:0] gidx [16];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (byte_valid) begin
      if (nbv < 16) begin got[nbv] = byte_data; gidx[nbv] = byte_idx; end
      nbv++;
    end
    if (frame_done) begin
      nfd++; fd_bytes = frame_bytes; fd_err = frame_err;
      if (byte_valid) same = 1'b1;
    end
    if (dev_reset) ndev++;
    if (prog_req)  nprog++;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    nbv = 0; nfd = 0; ndev = 0; nprog = 0; mmis = 0; same = 1'b0;
  endtask

  // Clocks bits out; with merge set, the final falling edge and the
  // select release are driven together.
  task automatic shift_bits(input int nbits, input logic [79:0] d, input bit merge);
    for (int i = 0; i < nbits; i++) begin
      mosi = d[79-i];
      sck  = 1'b1;
      wait_cyc(HALF);
      if (miso !== TX[7-(i%8)]) mmis++;
      sck = 1'b0;
      if (merge && i == nbits - 1) cs_n = 1'b1;
      wait_cyc(HALF);
    end
  endtask

  task automatic send_frame(input int nbits, input logic [79:0] d, input bit merge);
    cs_n = 1'b0;
    wait_cyc(HALF);
    shift_bits(nbits, d, merge);
    cs_n = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic pin_edge(input logic sck_lvl);
    rpin = 1'b0; wait_cyc(10);
    sck  = sck_lvl; wait_cyc(10);
    rpin = 1'b1; wait_cyc(15);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; mosi = 1'b0; cs_n = 1'b1; rpin = 1'b1; tx_byte = TX;
    clear_mon();
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R11: reset state
    chk({byte_valid, frame_done, frame_err, dev_reset, prog_req, miso} == 6'b0,
        "R11 reset outputs", {byte_valid, frame_done, frame_err, dev_reset, prog_req, miso}, 0);

    // Vector table: R1, R2, R3, R4, R7
    for (int v = 0; v < NV; v++) begin
      int nb, nbits;
      logic eerr;
      logic [79:0] d;
      nbits = int'(VEC[v][87:80]);
      d     = VEC[v][79:0];
      nb    = (nbits / 8 > 9) ? 9 : nbits / 8;
      eerr  = (nbits % 8 != 0) || (nbits > 72);
      clear_mon();
      send_frame(nbits, d, 1'b0);
      chk(nfd == 1, "R2 one frame_done", nfd, 1);
      chk(fd_bytes == 4'(nb), "R2/R4 frame_bytes", fd_bytes, nb);
      chk(fd_err == eerr, "R3/R4 frame_err", fd_err, eerr);
      chk(nbv == nb, "R1/R3/R4 byte_valid count", nbv, nb);
      for (int k = 0; k < nb && k < 16; k++) begin
        chk(got[k] == d[79-8*k -: 8], "R1 byte value", got[k], d[79-8*k -: 8]);
        chk(gidx[k] == 4'(k), "R1 byte index", gidx[k], k);
      end
      chk(mmis == 0, "R7 miso bits", mmis, 0);
    end

    // R5: activity with select high is ignored
    clear_mon();
    for (int i = 0; i < 10; i++) begin
      mosi = 1'b1; sck = 1'b1; wait_cyc(HALF); sck = 1'b0; wait_cyc(HALF);
    end
    chk(nbv == 0 && nfd == 0, "R5 idle clocks ignored", nbv + nfd, 0);
    send_frame(8, 80'h5A_000000000000000000, 1'b0);
    chk(nbv == 1 && got[0] == 8'h5A && fd_bytes == 4'd1, "R5 next frame intact", got[0], 8'h5A);

    // R6: single-cycle glitches on clock and select
    clear_mon();
    cs_n = 1'b0; wait_cyc(HALF);
    shift_bits(8, 80'h3C_000000000000000000, 1'b0);
    sck = 1'b1; wait_cyc(1); sck = 1'b0; wait_cyc(HALF);
    cs_n = 1'b1; wait_cyc(1); cs_n = 1'b0; wait_cyc(HALF);
    chk(nfd == 0, "R6 select glitch no frame end", nfd, 0);
    cs_n = 1'b1; wait_cyc(HALF);
    chk(nfd == 1 && fd_bytes == 4'd1 && !fd_err, "R6 clock glitch no extra bit", {fd_err, fd_bytes}, 1);
    chk(got[0] == 8'h3C, "R6 byte intact", got[0], 8'h3C);

    // R10: last falling edge and select release in the same cycle
    clear_mon();
    send_frame(16, 80'hA1B2_0000000000000000, 1'b1);
    chk(same == 1'b1, "R10 byte_valid with frame_done", same, 1);
    chk(fd_bytes == 4'd2 && !fd_err, "R10 final byte counted", {fd_err, fd_bytes}, 2);
    chk(nbv == 2 && got[1] == 8'hB2, "R10 final byte value", got[1], 8'hB2);

    // R8: reset pin edge, clock high then low
    clear_mon();
    pin_edge(1'b1);
    chk(ndev == 1 && nprog == 0, "R8 ordinary reset", {ndev[3:0], nprog[3:0]}, 8'h10);
    sck = 1'b0; wait_cyc(10);
    clear_mon();
    pin_edge(1'b0);
    chk(nprog == 1 && ndev == 0, "R8 programming request", {ndev[3:0], nprog[3:0]}, 8'h01);

    // R9: reset pin edge inside a frame abandons it
    clear_mon();
    cs_n = 1'b0; wait_cyc(HALF);
    shift_bits(8, 80'h77_000000000000000000, 1'b0);
    pin_edge(1'b1);
    sck = 1'b0; wait_cyc(HALF);
    cs_n = 1'b1; wait_cyc(HALF);
    chk(nfd == 0 && ndev == 1, "R9 frame abandoned", nfd, 0);
    send_frame(8, 80'h96_000000000000000000, 1'b0);
    chk(nfd == 1 && fd_bytes == 4'd1 && got[1] == 8'h96, "R9 recovery frame", got[1], 8'h96);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule